// File: doc/BRIEF.md
# Resolver Fault Flag Logic

This block sits behind the digital tracking loop of a resolver-to-digital converter and condenses its health measurements into two active-low fault pins, `dos_n` (signal degradation) and `lot_n` (tracking loss). Each cycle it receives four measurements from the loop. The first is a monitor magnitude, qualified by `mon_vld`. The other three are the loop error angle, the gap between the integrator position and the output position, and the rate magnitude. A `sample` strobe also arrives each cycle, and its rising edge re-arms the latched faults.

There are three fault classes. Loss of signal, meaning the monitor magnitude is too small, drives both pins low and stays latched. Degradation, meaning the monitor is over range or its running min-to-max spread is too wide, drives only `dos_n` low. Tracking loss drives only `lot_n` low. It has hysteresis: it sets above a 5-degree angle or above the rate limit, and clears only once the angles are under 1 degree. The classes have a fixed priority, so a single pin is low only for one class. Both pins low always means loss of signal.

All thresholds and widths are parameters. With 12-bit angles, 5 degrees is taken as 57 LSB and 1 degree as 11 LSB.

Top module: `resolver_fault_flags`

## Requirements
- R1: While reset is asserted, and after reset until the first rising edge of `sample`, both `dos_n` and `lot_n` are low.
- R2: A valid monitor value strictly below `LOS_TH` drives both pins low at the next clock edge. The indication stays latched until a rising edge of `sample` with no new low value in that cycle. Holding `sample` high does not clear it.
- R3: A valid monitor value strictly above `OVER_TH` gives `dos_n` low and `lot_n` high. This is not latched: the next valid in-range value releases `dos_n`.
- R4: The block keeps the running minimum and maximum of the valid monitor values. When max minus min exceeds `SPREAD_TH`, `dos_n` goes low and stays latched until a rising edge of `sample`.
- R5: A rising edge of `sample` empties the min/max window. The value valid in that cycle starts the new window, so values seen before the edge no longer count toward the spread.
- R6: `lot_n` goes low at the next edge when the error angle exceeds `TRK_SET` (57), when the position gap exceeds `TRK_SET`, or when the rate exceeds `RATE_MAX`. Values equal to the limit do not set it.
- R7: Once set, tracking loss stays set until, in a single cycle, error angle < `TRK_CLR` (11), position gap < `TRK_CLR` and rate ≤ `RATE_MAX`. It is never latched beyond that.
- R8: The pin encoding is: loss of signal gives both low; degradation gives (`dos_n`=0, `lot_n`=1); tracking loss alone gives (`dos_n`=1, `lot_n`=0); no fault gives both high. Loss outranks degradation, and degradation outranks tracking loss.
- R9: When `mon_vld` is low, `mon_mag` is ignored. It neither sets nor clears any monitor-based fault, and it does not enter the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_vld | input | 1 | Qualifies `mon_mag` for this cycle |
| mon_mag | input | MON_W | Monitor magnitude |
| err_ang | input | ANG_W | Loop error angle magnitude |
| pos_mis | input | ANG_W | Integrator versus output position gap magnitude |
| rate_mag | input | RATE_W | Rate magnitude |
| sample | input | 1 | Strobe; rising edge clears latches and the window |
| dos_n | output | 1 | Degradation / loss pin, active low |
| lot_n | output | 1 | Tracking / loss pin, active low |

## Verification
The bench aims at the corner cases where the rules interact.

- **Strobe held high.** A second high cycle must not count as a new edge, or a loss latched during it would vanish.
- **Window restart.** A spread that straddles a restart must not trip. A design that keeps its old minimum would latch degradation falsely.
- **Tracking-loss band.** Error values of exactly 57 and 11 fall inside the hysteresis band. A design without hysteresis would release `lot_n` there.
- **Class collisions.** Over-range arrives together with a large error, and then loss joins them. A design with the wrong priority would show both pins low for degradation, or a lone `lot_n` during degradation.

// File: rtl/resolver_fault_pkg.sv
package resolver_fault_pkg;

   // Fault class, ordered from lowest to highest priority.
   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_TRACK   = 2'd1,
      FLT_DEGRADE = 2'd2,
      FLT_LOSS    = 2'd3
   } fault_class_e;

   // Resolve the three raw causes into one class by priority.
   function automatic fault_class_e pick_class(input logic loss,
                                               input logic degrade,
                                               input logic track);
      if (loss)         return FLT_LOSS;
      else if (degrade) return FLT_DEGRADE;
      else if (track)   return FLT_TRACK;
      else              return FLT_NONE;
   endfunction

   // Pin pattern {dos_n, lot_n} for a class.
   function automatic logic [1:0] class_pins(input fault_class_e c);
      case (c)
         FLT_LOSS:    return 2'b00;
         FLT_DEGRADE: return 2'b01;
         FLT_TRACK:   return 2'b10;
         default:     return 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/resolver_mon_window.sv
module resolver_mon_window #(
   parameter int W         = 10,
   parameter int SPREAD_TH = 100
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld,
   input  logic [W-1:0] mag,
   input  logic         restart,
   output logic         spread_flag
);
   localparam logic [W-1:0] SPREAD_V = W'(SPREAD_TH);

   logic         seen_q;
   logic [W-1:0] lo_q, hi_q;
   logic         flag_q;
   logic         base_seen;
   logic [W-1:0] lo_n, hi_n;
   logic         wide;

   always_comb begin
      base_seen = seen_q && !restart;
      lo_n = lo_q;
      hi_n = hi_q;
      if (vld) begin
         if (!base_seen) begin
            lo_n = mag;
            hi_n = mag;
         end else begin
            if (mag < lo_q) lo_n = mag;
            if (mag > hi_q) hi_n = mag;
         end
      end
      wide = vld && ((hi_n - lo_n) > SPREAD_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         lo_q   <= '0;
         hi_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         seen_q <= base_seen || vld;
         lo_q   <= lo_n;
         hi_q   <= hi_n;
         if (wide)         flag_q <= 1'b1;
         else if (restart) flag_q <= 1'b0;
      end
   end

   assign spread_flag = flag_q;

   assert_window_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (lo_q <= hi_q));

   assert_spread_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !restart) |=> flag_q);

   assert_restart_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && vld) |=> (seen_q && lo_q == hi_q));

endmodule

// File: rtl/resolver_track_hyst.sv
module resolver_track_hyst #(
   parameter int ANG_W    = 12,
   parameter int RATE_W   = 12,
   parameter int SET_TH   = 57,
   parameter int CLR_TH   = 11,
   parameter int RATE_MAX = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ANG_W-1:0]  err_ang,
   input  logic [ANG_W-1:0]  pos_mis,
   input  logic [RATE_W-1:0] rate_mag,
   output logic              trk_flag
);
   localparam logic [ANG_W-1:0]  SET_V  = ANG_W'(SET_TH);
   localparam logic [ANG_W-1:0]  CLR_V  = ANG_W'(CLR_TH);
   localparam logic [RATE_W-1:0] RATE_V = RATE_W'(RATE_MAX);

   logic lot_q;
   logic go_bad, go_good;

   always_comb begin
      go_bad  = (err_ang > SET_V) || (pos_mis > SET_V) || (rate_mag > RATE_V);
      go_good = (err_ang < CLR_V) && (pos_mis < CLR_V) && (rate_mag <= RATE_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lot_q <= 1'b1;
      else if (go_bad)  lot_q <= 1'b1;
      else if (go_good) lot_q <= 1'b0;
   end

   assign trk_flag = lot_q;

   assert_track_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_ang > SET_V) || (pos_mis > SET_V) || (rate_mag > RATE_V)) |=> lot_q);

   assert_track_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lot_q && !((err_ang < CLR_V) && (pos_mis < CLR_V) && (rate_mag <= RATE_V))) |=> lot_q);

endmodule

// File: rtl/resolver_fault_flags.sv
module resolver_fault_flags
   import resolver_fault_pkg::*;
#(
   parameter int MON_W     = 10,
   parameter int ANG_W     = 12,
   parameter int RATE_W    = 12,
   parameter int LOS_TH    = 300,
   parameter int OVER_TH   = 900,
   parameter int SPREAD_TH = 100,
   parameter int TRK_SET   = 57,
   parameter int TRK_CLR   = 11,
   parameter int RATE_MAX  = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_vld,
   input  logic [MON_W-1:0]  mon_mag,
   input  logic [ANG_W-1:0]  err_ang,
   input  logic [ANG_W-1:0]  pos_mis,
   input  logic [RATE_W-1:0] rate_mag,
   input  logic              sample,
   output logic              dos_n,
   output logic              lot_n
);
   localparam logic [MON_W-1:0] LOS_V  = MON_W'(LOS_TH);
   localparam logic [MON_W-1:0] OVER_V = MON_W'(OVER_TH);

   // Elaboration-time parameter checks.
   if (LOS_TH >= OVER_TH) begin : g_bad_levels
      $error("LOS_TH must be below OVER_TH");
   end
   if (TRK_CLR >= TRK_SET) begin : g_bad_band
      $error("TRK_CLR must be below TRK_SET");
   end
   if (OVER_TH >= (1 << MON_W)) begin : g_bad_width
      $error("OVER_TH does not fit in MON_W");
   end

   logic         smp_q;
   logic         smp_rise;
   logic         loss_q;
   logic         over_q;
   logic         spread_flag;
   logic         trk_flag;
   logic         degrade;
   fault_class_e cls;
   logic [1:0]   pins;

   assign smp_rise = sample && !smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= 1'b0;
         loss_q <= 1'b1;
         over_q <= 1'b0;
      end else begin
         smp_q <= sample;
         if (mon_vld && (mon_mag < LOS_V)) loss_q <= 1'b1;
         else if (smp_rise)                loss_q <= 1'b0;
         if (mon_vld) over_q <= (mon_mag > OVER_V);
      end
   end

   resolver_mon_window #(
      .W         (MON_W),
      .SPREAD_TH (SPREAD_TH)
   ) u_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .vld         (mon_vld),
      .mag         (mon_mag),
      .restart     (smp_rise),
      .spread_flag (spread_flag)
   );

   resolver_track_hyst #(
      .ANG_W    (ANG_W),
      .RATE_W   (RATE_W),
      .SET_TH   (TRK_SET),
      .CLR_TH   (TRK_CLR),
      .RATE_MAX (RATE_MAX)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_ang  (err_ang),
      .pos_mis  (pos_mis),
      .rate_mag (rate_mag),
      .trk_flag (trk_flag)
   );

   always_comb begin
      degrade = over_q || spread_flag;
      cls     = pick_class(loss_q, degrade, trk_flag);
      pins    = class_pins(cls);
   end

   assign dos_n = pins[1];
   assign lot_n = pins[0];

   assert_loss_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dos_n && !lot_n && !smp_rise) |=> (!dos_n && !lot_n));

   assert_low_sets_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_vld && (mon_mag < LOS_V)) |=> (!dos_n && !lot_n));

   assert_over_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_vld && (mon_mag > OVER_V)) |=> !dos_n);

   assert_lone_lot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lot_n && dos_n) |-> (trk_flag && !spread_flag && !over_q));

   assert_degrade_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dos_n && !loss_q) |-> lot_n);

endmodule

// File: tb/sim_resolver_fault_flags.sv
module sim_resolver_fault_flags;
   localparam int CLK_PERIOD = 10;
   localparam int LOS  = 300;
   localparam int OVER = 900;
   localparam int SPR  = 100;
   localparam int SETA = 57;
   localparam int CLRA = 11;
   localparam int RMAX = 2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_vld = 1'b0;
   logic [9:0]  mon_mag = '0;
   logic [11:0] err_ang = '0;
   logic [11:0] pos_mis = '0;
   logic [11:0] rate_mag = '0;
   logic        sample = 1'b0;
   logic        dos_n, lot_n;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   // reference state
   bit m_loss, m_seen, m_spread, m_over, m_trk, m_prev;
   int m_lo, m_hi;

   always #(CLK_PERIOD/2) clk = ~clk;

   resolver_fault_flags u0 (
      .clk(clk), .rst_n(rst_n), .mon_vld(mon_vld), .mon_mag(mon_mag),
      .err_ang(err_ang), .pos_mis(pos_mis), .rate_mag(rate_mag),
      .sample(sample), .dos_n(dos_n), .lot_n(lot_n)
   );

   function automatic bit exp_dos();
      return !(m_loss || m_over || m_spread);
   endfunction

   function automatic bit exp_lot();
      return !(m_loss || (m_trk && !(m_over || m_spread)));
   endfunction

   task automatic model_reset();
      m_loss = 1; m_seen = 0; m_spread = 0; m_over = 0; m_trk = 1; m_prev = 0;
      m_lo = 0; m_hi = 0;
   endtask

   task automatic model_step(bit v, int m, int e, int p, int r, bit s);
      bit rise;
      rise = s && !m_prev;
      m_prev = s;
      if (v && m < LOS) m_loss = 1; else if (rise) m_loss = 0;
      if (rise) m_seen = 0;
      if (v) begin
         if (!m_seen) begin m_lo = m; m_hi = m; end
         else begin
            if (m < m_lo) m_lo = m;
            if (m > m_hi) m_hi = m;
         end
         m_seen = 1;
      end
      if (v && (m_hi - m_lo) > SPR) m_spread = 1; else if (rise) m_spread = 0;
      if (v) m_over = (m > OVER);
      if (e > SETA || p > SETA || r > RMAX) m_trk = 1;
      else if (e < CLRA && p < CLRA && r <= RMAX) m_trk = 0;
   endtask

   task automatic step(bit v, int m, int e, int p, int r, bit s);
      @(negedge clk);
      mon_vld = v; mon_mag = 10'(m); err_ang = 12'(e); pos_mis = 12'(p);
      rate_mag = 12'(r); sample = s;
      @(posedge clk);
      model_step(v, m, e, p, r, s);
      #1;
   endtask

   task automatic chk(string tag, bit ed, bit el);
      tests++;
      if (dos_n !== ed || lot_n !== el) begin
         fails++;
         $display("FAIL %s: dos_n/lot_n = %b/%b expected %b/%b", tag, dos_n, lot_n, ed, el);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      model_reset();
      repeat (3) @(posedge clk);
      #1 chk("R1 in reset", 0, 0);
      @(negedge clk); rst_n = 1'b1;
      #1 chk("R1 after release", 0, 0);
      step(1, 600, 0, 0, 0, 0); chk("R1 held until strobe", 0, 0);
      step(1, 600, 0, 0, 0, 1); chk("R1 cleared by strobe edge", 1, 1);

      // R2 loss latch, held-high strobe is not an edge
      step(1, 250, 0, 0, 0, 1); chk("R2 low value while strobe held", 0, 0);
      step(1, 600, 0, 0, 0, 0); chk("R2 loss stays latched", 0, 0);
      step(1, 850, 0, 0, 0, 1); chk("R2 edge releases loss", 1, 1);

      // R3 over level, not latched
      step(1, 905, 0, 0, 0, 0); chk("R3 over level", 0, 1);
      step(1, 850, 0, 0, 0, 0); chk("R3 released by in-range value", 1, 1);

      // R4 spread latch, R5 restart
      step(1, 600, 0, 0, 0, 1); chk("R5 restart window", 1, 1);
      step(1, 650, 0, 0, 0, 0); chk("R4 spread 50", 1, 1);
      step(1, 560, 0, 0, 0, 0); chk("R4 spread 90", 1, 1);
      step(1, 540, 0, 0, 0, 0); chk("R4 spread 110 trips", 0, 1);
      step(1, 600, 0, 0, 0, 0); chk("R4 spread latched", 0, 1);
      step(1, 600, 0, 0, 0, 1); chk("R5 edge clears spread", 1, 1);
      step(1, 690, 0, 0, 0, 0); chk("R5 old minimum forgotten", 1, 1);

      // R9 invalid monitor ignored
      step(0, 100, 0, 0, 0, 0); chk("R9 invalid low value", 1, 1);
      step(0, 1000, 0, 0, 0, 0); chk("R9 invalid high value", 1, 1);
      step(1, 650, 0, 0, 0, 0); chk("R9 window untouched", 1, 1);

      // R6 / R7 tracking loss
      step(1, 650, 58, 0, 0, 0); chk("R6 error 58", 1, 0);
      step(1, 650, 57, 0, 0, 0); chk("R7 error 57 in band", 1, 0);
      step(1, 650, 11, 0, 0, 0); chk("R7 error 11 in band", 1, 0);
      step(1, 650, 10, 0, 0, 0); chk("R7 error 10 clears", 1, 1);
      step(1, 650, 0, 58, 0, 0); chk("R6 position gap 58", 1, 0);
      step(1, 650, 0, 11, 0, 0); chk("R7 gap 11 in band", 1, 0);
      step(1, 650, 0, 5, 0, 0);  chk("R7 gap 5 clears", 1, 1);
      step(1, 650, 0, 20, RMAX+1, 0); chk("R6 overspeed", 1, 0);
      step(1, 650, 0, 20, 0, 0); chk("R7 rate ok but gap 20", 1, 0);
      step(1, 650, 0, 0, 0, 0);  chk("R7 all clear", 1, 1);
      step(1, 650, 0, 0, RMAX, 0); chk("R6 rate at limit", 1, 1);
      step(1, 650, 57, 0, 0, 0); chk("R6 error at 57 does not set", 1, 1);

      // R8 priority
      step(1, 850, 0, 0, 0, 1);   chk("R8 fresh window", 1, 1);
      step(1, 905, 100, 0, 0, 0); chk("R8 degrade over tracking", 0, 1);
      step(1, 850, 100, 0, 0, 0); chk("R8 tracking alone", 1, 0);
      step(1, 250, 100, 0, 0, 0); chk("R8 loss over all", 0, 0);
      step(1, 600, 0, 0, 0, 1);   chk("R8 all cleared", 1, 1);

      // random phase against the reference
      for (int i = 0; i < 3000; i++) begin
         bit v, s;
         int m, e, p, r;
         v = ($urandom % 5) != 0;
         s = ($urandom % 12) == 0;
         m = 200 + ($urandom % 800);
         e = (($urandom % 4) == 0) ? ($urandom % 100) : ($urandom % 15);
         p = (($urandom % 6) == 0) ? ($urandom % 80) : ($urandom % 12);
         r = (($urandom % 8) == 0) ? (RMAX - 5 + ($urandom % 10)) : ($urandom % 1500);
         step(v, m, e, p, r, s);
         chk("R8 random vs reference", exp_dos(), exp_lot());
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule